// File: doc/BRIEF.md
# Supply-Pulse Programming Decoder

This block turns a stream of quantised supply levels into programming commands for a small one-time-programmable calibration store. The supply is sampled once per clock as one of four levels. A run meter measures how long each level lasts. A sequencer waits for an arming pattern of three pulses. It then counts mid-level pulses to form an address, and acts on the high pulse that closes the sequence. A short closing pulse makes a provisional, volatile setting. A long closing pulse blows fuses and raises a one-cycle strobe that carries the address.

The calibration code seen by the rest of the chip is the OR of the fuse bits and the volatile bits. Any drop of the supply to zero discards the volatile bits and any sequence in progress. Address 32 is the lock. Once the lock fuse is blown, every later sequence is ignored.

Top module: `supply_prog_decoder`

## Requirements
- R1: After `rst_ni` is released, `code_o`, `fuse_o`, `locked_o`, `blow_o` and `addr_mode_o` are all zero.
- R2: `level_i` is encoded as 00 = zero, 01 = low, 10 = mid, 11 = high. `addr_mode_o` rises only after this exact pattern: a short high pulse, a mid pulse, then a short high pulse, each separated by low gaps. Any other order leaves it low.
- R3: In address mode, the address is the number of mid pulses received. A closing short high pulse (width from `T_SHORT` to `T_BLOW`-1 cycles) ORs an address of 1 to 31 into the volatile code. `code_o` equals the OR of the volatile code and `fuse_o`.
- R4: Provisional settings from successive sequences accumulate by OR for as long as the supply does not reach zero.
- R5: Any cycle sampled at zero clears the volatile code and leaves address mode. Fuse bits are unaffected.
- R6: A mid or high pulse shorter than `T_SHORT` cycles aborts the sequence. So does a low gap shorter than `T_GAP` cycles between pulses. A pulse of exactly `T_SHORT` cycles and a gap of exactly `T_GAP` cycles are accepted.
- R7: A closing high pulse of at least `T_BLOW` cycles is a blow. In the cycle after the pulse ends at low, `blow_o` is high for exactly one cycle with the address on `blow_addr_o`, and addresses 1 to 31 are ORed into `fuse_o`.
- R8: A blow at address 32 sets `locked_o`. After that, no sequence enters address mode, changes the code or strobes `blow_o`. Address 0 or above 32 produces no strobe and no change. A try at address 32 has no effect.
- R9: Fuse bits and `locked_o` never clear except by `rst_ni`.
- R10: If the closing pulse ends directly into zero, the zero wins: no strobe is issued and neither store changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| level_i | input | 2 | Quantised supply level |
| code_o | output | CODE_W | Effective calibration code |
| fuse_o | output | CODE_W | Blown calibration fuse bits |
| locked_o | output | 1 | Lock fuse blown |
| addr_mode_o | output | 1 | Arming pattern accepted, counting address |
| blow_o | output | 1 | One-cycle fuse-blow strobe |
| blow_addr_o | output | CODE_W+1 | Address accompanying the strobe |

## Verification
The end of a closing pulse and a drop to zero can land on the same clock edge. The pulse-end event and the clear are then decided together. The bench provokes this by switching the supply from a blow-width high straight to zero, without the low level in between. It judges the result at the ports: there must be no `blow_o` strobe, and `fuse_o` and `code_o` must be unchanged. A bound property also ties every zero sample to a quiet strobe on the next cycle.

// File: rtl/spd_pkg.sv
package spd_pkg;
  typedef enum logic [1:0] {
    LVL_ZERO = 2'b00,
    LVL_LOW  = 2'b01,
    LVL_MID  = 2'b10,
    LVL_HIGH = 2'b11
  } lvl_e;

  // run that just ended, classified by width
  typedef struct packed {
    logic valid;
    lvl_e lvl;
    logic runt;       // shorter than minimum pulse
    logic long_p;     // blow-width
    logic gap_short;  // low gap below minimum
  } seg_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_KEY1,
    ST_KEY2,
    ST_ADDR
  } seq_e;
endpackage

// File: rtl/spd_run_meter.sv
module spd_run_meter
  import spd_pkg::*;
#(
  parameter int T_SHORT = 4,
  parameter int T_GAP   = 4,
  parameter int T_BLOW  = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  lvl_e lvl_i,
  output seg_t seg_o
);
  localparam int CNT_MAX = (T_BLOW > T_GAP) ? T_BLOW : T_GAP;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  lvl_e             prev_q;
  logic [CNT_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= LVL_ZERO;
      run_q  <= '0;
    end else if (lvl_i != prev_q) begin
      prev_q <= lvl_i;
      run_q  <= CNT_W'(1);
    end else if (run_q != CNT_W'(CNT_MAX)) begin
      run_q  <= run_q + CNT_W'(1);
    end
  end

  always_comb begin
    seg_o.valid     = (lvl_i != prev_q);
    seg_o.lvl       = prev_q;
    seg_o.runt      = (run_q < CNT_W'(T_SHORT));
    seg_o.long_p    = (run_q >= CNT_W'(T_BLOW));
    seg_o.gap_short = (run_q < CNT_W'(T_GAP));
  end
endmodule

// File: rtl/spd_seq_fsm.sv
module spd_seq_fsm
  import spd_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  seg_t              seg_i,
  input  logic              zero_i,
  input  logic              locked_i,
  output logic              try_o,
  output logic              blow_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_mode_o
);
  seq_e              st_q, st_d;
  logic [ADDR_W-1:0] cnt_q, cnt_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    try_o  = 1'b0;
    blow_o = 1'b0;
    if (seg_i.valid) begin
      if (seg_i.lvl == LVL_LOW) begin
        if (seg_i.gap_short) st_d = ST_IDLE;
      end else begin
        unique case (st_q)
          ST_IDLE: begin
            if (seg_i.lvl == LVL_HIGH && !seg_i.runt && !seg_i.long_p) st_d = ST_KEY1;
          end
          ST_KEY1: begin
            st_d = (seg_i.lvl == LVL_MID && !seg_i.runt) ? ST_KEY2 : ST_IDLE;
          end
          ST_KEY2: begin
            if (seg_i.lvl == LVL_HIGH && !seg_i.runt && !seg_i.long_p) begin
              st_d  = ST_ADDR;
              cnt_d = '0;
            end else begin
              st_d = ST_IDLE;
            end
          end
          ST_ADDR: begin
            if (seg_i.lvl == LVL_MID && !seg_i.runt) begin
              if (cnt_q != '1) cnt_d = cnt_q + ADDR_W'(1);
            end else begin
              st_d = ST_IDLE;
              if (seg_i.lvl == LVL_HIGH && !seg_i.runt) begin
                blow_o = seg_i.long_p;
                try_o  = !seg_i.long_p;
              end
            end
          end
          default: st_d = ST_IDLE;
        endcase
      end
    end
    // a zero sample or a blown lock overrides everything
    if (zero_i || locked_i) begin
      st_d   = ST_IDLE;
      try_o  = 1'b0;
      blow_o = 1'b0;
    end
  end

  assign addr_o      = cnt_q;
  assign addr_mode_o = (st_q == ST_ADDR);
endmodule

// File: rtl/spd_bit_store.sv
module spd_bit_store #(
  parameter int CODE_W = 5,
  parameter int ADDR_W = CODE_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              try_i,
  input  logic              blow_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              zero_i,
  output logic [CODE_W-1:0] vol_o,
  output logic [CODE_W-1:0] fuse_o,
  output logic              lock_o,
  output logic              strobe_o,
  output logic [ADDR_W-1:0] strobe_addr_o
);
  localparam int LOCK_ADDR = 1 << CODE_W;

  logic [CODE_W-1:0] vol_q, fuse_q;
  logic              lock_q, strobe_q;
  logic [ADDR_W-1:0] saddr_q;
  logic              is_code, is_lock;

  assign is_code = (addr_i != '0) && (addr_i < ADDR_W'(LOCK_ADDR));
  assign is_lock = (addr_i == ADDR_W'(LOCK_ADDR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vol_q    <= '0;
      fuse_q   <= '0;
      lock_q   <= 1'b0;
      strobe_q <= 1'b0;
      saddr_q  <= '0;
    end else begin
      strobe_q <= blow_i && (is_code || is_lock);
      if (blow_i && (is_code || is_lock)) saddr_q <= addr_i;
      if (blow_i && is_code) fuse_q <= fuse_q | addr_i[CODE_W-1:0];
      if (blow_i && is_lock) lock_q <= 1'b1;
      if (zero_i)                vol_q <= '0;
      else if (try_i && is_code) vol_q <= vol_q | addr_i[CODE_W-1:0];
    end
  end

  assign vol_o         = vol_q;
  assign fuse_o        = fuse_q;
  assign lock_o        = lock_q;
  assign strobe_o      = strobe_q;
  assign strobe_addr_o = saddr_q;
endmodule

// File: rtl/supply_prog_decoder.sv
module supply_prog_decoder
  import spd_pkg::*;
#(
  parameter int CODE_W  = 5,
  parameter int T_SHORT = 4,
  parameter int T_GAP   = 4,
  parameter int T_BLOW  = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        level_i,
  output logic [CODE_W-1:0] code_o,
  output logic [CODE_W-1:0] fuse_o,
  output logic              locked_o,
  output logic              addr_mode_o,
  output logic              blow_o,
  output logic [CODE_W:0]   blow_addr_o
);
  localparam int ADDR_W = CODE_W + 1;

  lvl_e              lvl;
  seg_t              seg;
  logic              zero, try_c, blow_c, lock;
  logic [ADDR_W-1:0] addr;
  logic [CODE_W-1:0] vol, fuse;

  assign lvl  = lvl_e'(level_i);
  assign zero = (lvl == LVL_ZERO);

  spd_run_meter #(.T_SHORT(T_SHORT), .T_GAP(T_GAP), .T_BLOW(T_BLOW)) meter_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (lvl),
    .seg_o (seg)
  );

  spd_seq_fsm #(.ADDR_W(ADDR_W)) fsm_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .seg_i      (seg),
    .zero_i     (zero),
    .locked_i   (lock),
    .try_o      (try_c),
    .blow_o     (blow_c),
    .addr_o     (addr),
    .addr_mode_o(addr_mode_o)
  );

  spd_bit_store #(.CODE_W(CODE_W), .ADDR_W(ADDR_W)) store_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .try_i        (try_c),
    .blow_i       (blow_c),
    .addr_i       (addr),
    .zero_i       (zero),
    .vol_o        (vol),
    .fuse_o       (fuse),
    .lock_o       (lock),
    .strobe_o     (blow_o),
    .strobe_addr_o(blow_addr_o)
  );

  assign code_o   = vol | fuse;
  assign fuse_o   = fuse;
  assign locked_o = lock;
endmodule

// File: rtl/spd_checker.sv
module spd_checker #(
  parameter int CODE_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        level_i,
  input logic [CODE_W-1:0] code_o,
  input logic [CODE_W-1:0] fuse_o,
  input logic              locked_o,
  input logic              addr_mode_o,
  input logic              blow_o,
  input logic [CODE_W:0]   blow_addr_o
);
  AST_ZERO_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i == 2'b00) |=> (code_o == fuse_o) && !addr_mode_o);  // R5

  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blow_o |=> !blow_o);  // R7

  AST_STROBE_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blow_o |-> (blow_addr_o != '0) && (blow_addr_o <= (CODE_W+1)'(1 << CODE_W)));  // R8

  AST_LOCK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |=> !blow_o && !addr_mode_o && $stable(fuse_o));  // R8

  AST_FUSE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(fuse_o) & ~fuse_o) == '0) && ($past(locked_o) -> locked_o));  // R9

  AST_ZERO_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i == 2'b00) |=> !blow_o);  // R10
endmodule

bind supply_prog_decoder spd_checker #(.CODE_W(CODE_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .level_i    (level_i),
  .code_o     (code_o),
  .fuse_o     (fuse_o),
  .locked_o   (locked_o),
  .addr_mode_o(addr_mode_o),
  .blow_o     (blow_o),
  .blow_addr_o(blow_addr_o)
);

// File: tb/supply_prog_decoder_tb_top.sv
module supply_prog_decoder_tb_top;
  localparam int CW = 5;
  localparam int TS = 4;
  localparam int TG = 4;
  localparam int TB = 20;
  localparam logic [1:0] Z = 2'b00, L = 2'b01, M = 2'b10, H = 2'b11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    lvl = Z;
  logic [CW-1:0] code, fuse;
  logic          locked, mode, blow;
  logic [CW:0]   baddr;
  int            n_chk = 0, n_fail = 0;
  bit            done = 0;
  int            exp_fuse = 0;

  always #2.5ns clk = ~clk;

  supply_prog_decoder #(.CODE_W(CW), .T_SHORT(TS), .T_GAP(TG), .T_BLOW(TB)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .level_i(lvl), .code_o(code), .fuse_o(fuse),
    .locked_o(locked), .addr_mode_o(mode), .blow_o(blow), .blow_addr_o(baddr)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic hold(input logic [1:0] l, input int n);
    for (int i = 0; i < n; i++) begin
      lvl = l;
      @(negedge clk);
    end
  endtask

  // full sequence; returns one cycle after the closing pulse ends at end_lvl
  task automatic seq(input int n_mid, input int end_len, input int mid_w,
                     input int gap, input logic [1:0] end_lvl);
    hold(H, TS); hold(L, gap);
    hold(M, mid_w); hold(L, gap);
    hold(H, TS); hold(L, gap);
    for (int i = 0; i < n_mid; i++) begin
      hold(M, TS); hold(L, TG);
    end
    hold(H, end_len);
    hold(end_lvl, 1);
  endtask

  task automatic clear();
    hold(Z, 2); hold(L, 6);
  endtask

  initial begin
    #750us;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    hold(L, 3);
    // R1 reset state
    chk("R1 code", int'(code), 0);
    chk("R1 fuse", int'(fuse), 0);
    chk("R1 locked", int'(locked), 0);
    chk("R1 blow", int'(blow), 0);
    chk("R1 mode", int'(mode), 0);

    // R2 keying pattern opens address mode
    hold(H, TS); hold(L, TG); hold(M, TS); hold(L, TG); hold(H, TS); hold(L, 1);
    chk("R2 mode after key", int'(mode), 1);
    hold(Z, 1);
    chk("R5 zero leaves mode", int'(mode), 0);
    hold(L, 6);
    // R2 wrong order: mid, high, high
    hold(M, TS); hold(L, TG); hold(H, TS); hold(L, TG); hold(H, TS); hold(L, 1);
    chk("R2 wrong order", int'(mode), 0);
    clear();

    // R3/R8 sweep of try addresses 0..34
    for (int n = 0; n <= 34; n++) begin
      seq(n, TS, TS, TG, L);
      chk("R3 no strobe on try", int'(blow), 0);
      hold(L, 2);
      chk((n >= 1 && n <= 31) ? "R3 try code" : "R8 try out of range",
          int'(code), (n >= 1 && n <= 31) ? n : 0);
      clear();
    end

    // R4 accumulation, R5 clear
    seq(5, TS, TS, TG, L); hold(L, TG);
    seq(10, TS, TS, TG, L); hold(L, 2);
    chk("R4 accumulate", int'(code), 15);
    hold(Z, 1);
    chk("R5 zero clears code", int'(code), 0);
    hold(L, 6);

    // R6 width limits
    seq(3, TS, TS - 1, TG, L); hold(L, 2);
    chk("R6 runt mid in key", int'(code), 0);
    clear();
    seq(3, TS, TS, TG - 1, L); hold(L, 2);
    chk("R6 short gap", int'(code), 0);
    clear();
    seq(3, TS - 1, TS, TG, L); hold(L, 2);
    chk("R6 runt closing pulse", int'(code), 0);
    clear();

    // R7 blow
    seq(6, TB, TS, TG, L);
    chk("R7 strobe", int'(blow), 1);
    chk("R7 strobe addr", int'(baddr), 6);
    chk("R7 fuse", int'(fuse), 6);
    hold(L, 1);
    chk("R7 strobe one cycle", int'(blow), 0);
    exp_fuse = 6;
    hold(Z, 1);
    chk("R9 fuse kept after zero", int'(code), exp_fuse);
    hold(L, 6);
    seq(1, TB - 1, TS, TG, L);
    chk("R7 just under blow width", int'(blow), 0);
    hold(L, 1);
    chk("R7 try code", int'(code), 7);
    chk("R7 fuse unchanged", int'(fuse), exp_fuse);
    clear();
    chk("R5 fuse remains", int'(code), exp_fuse);

    // R8 out-of-range blows
    seq(33, TB, TS, TG, L);
    chk("R8 no strobe addr 33", int'(blow), 0);
    hold(L, 1);
    chk("R8 fuse addr 33", int'(fuse), exp_fuse);
    clear();
    seq(0, TB, TS, TG, L);
    chk("R8 no strobe addr 0", int'(blow), 0);
    clear();

    // R10 pulse end coincides with zero
    seq(9, TB, TS, TG, Z);
    chk("R10 no strobe", int'(blow), 0);
    chk("R10 fuse", int'(fuse), exp_fuse);
    hold(Z, 1);
    chk("R10 no late strobe", int'(blow), 0);
    hold(L, 6);

    // R8 lock
    seq(32, TB, TS, TG, L);
    chk("R8 lock strobe", int'(blow), 1);
    chk("R8 lock addr", int'(baddr), 32);
    chk("R8 locked", int'(locked), 1);
    chk("R8 lock keeps fuse", int'(fuse), exp_fuse);
    clear();
    hold(H, TS); hold(L, TG); hold(M, TS); hold(L, TG); hold(H, TS); hold(L, 1);
    chk("R8 no mode when locked", int'(mode), 0);
    clear();
    seq(8, TB, TS, TG, L);
    chk("R8 no strobe when locked", int'(blow), 0);
    hold(L, 1);
    chk("R8 fuse frozen", int'(fuse), exp_fuse);
    seq(1, TS, TS, TG, L); hold(L, 2);
    chk("R8 try ignored", int'(code), exp_fuse);
    hold(Z, 2);
    chk("R9 lock kept", int'(locked), 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule